// File: doc/BRIEF.md
# Host Adapter Interrupt Aggregator

This block folds the interrupt causes of several storage ports into a single interrupt towards the host. Every port holds a cause register, set bit by bit by event inputs and cleared by software with write-one-to-clear, and an enable register. When an evaluation finds a port whose causes and enables overlap, that port's bit is set in a sticky global status register. Software clears global status bits by writing 1s to them.

A global control register carries an interrupt-enable bit and a self-clearing adapter-reset bit. When interrupts are enabled and anything is pending, the block either emits a one-cycle message pulse (message mode, chosen by the `msi_en` input) or drives a level-sensitive legacy line. Evaluation is not continuous: any register write or cause event raises a one-cycle evaluation strobe in the following cycle, and the outputs act on that strobe. In message mode each strobe that finds work pending gives a fresh pulse. The legacy line is held by a two-state machine: LINE_IDLE moves to LINE_HELD on a strobe that finds work pending in legacy mode, and LINE_HELD moves back to LINE_IDLE on a strobe that finds nothing pending. Any reset forces LINE_IDLE.

Register addresses: 0 global control, 1 global status, 2+2p status of port p, 3+2p enable of port p. The control register reads bit 31 as constant 1 (adapter enabled) and bit 1 as interrupt enable.

Top module: `irqagg_top`

## Requirements
- R1: After reset, control reads 0x80000000, global status, every port status and enable read 0, and msi_pulse and irq_line are low.
- R2: A 1 on an evt_set bit sets that bit of the port status; a write of 1s to address 2+2p clears those bits; when an event and a clear hit the same bit in one cycle, the bit ends set.
- R3: A write to address 3+2p stores the data ANDed with 0xFDC000FF, so a cause in a masked position (such as bit 25) never reaches global status.
- R4: On an evaluation, global status bit p is set if port p status AND enable is nonzero; the bit stays set after the port is cleared, until 1 is written to it at address 1.
- R5: No pulse is produced and the line is not held unless control bit 1 is 1 and global status (including the bits set by this evaluation) is nonzero; clearing bit 1 releases a held line at the next evaluation.
- R6: With msi_en high, every evaluation that finds work pending gives msi_pulse high for exactly one cycle, and irq_line is not raised.
- R7: With msi_en low, an evaluation that finds work pending raises irq_line only if it is low; it stays high over later pending evaluations and falls only at an evaluation that finds nothing pending.
- R8: A control write with bit 0 set resets every register and drops irq_line at the clock edge that takes the write.
- R9: The evaluation strobe follows one cycle after the edge that takes a write or event, and the outputs change at the next edge: two edges after the stimulus, not one.
- R10: A control write without bit 0 sets interrupt enable to data bit 1; other data bits are ignored and bit 31 keeps reading 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msi_en | input | 1 | 1 selects message pulses, 0 the legacy line |
| evt_set | input | NPORTS x REG_W | Per-port cause set bits |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | REG_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | REG_W | Register read data, combinational |
| msi_pulse | output | 1 | One-cycle message interrupt pulse |
| irq_line | output | 1 | Level-sensitive legacy interrupt |

## Verification
The bench builds the block with four 32-bit ports and the default enable mask 0xFDC000FF. Four ports put both the lowest and highest register addresses in reach, let one port carry a masked-out cause (bit 25) and another a same-cycle set and clear, and leave enough ports to keep the global status sticky bits apart while the mode input switches between pulse and line.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    typedef enum logic [0:0] {
        LINE_IDLE = 1'b0,
        LINE_HELD = 1'b1
    } line_state_e;

    localparam int CTRL_AE_BIT = 31;
    localparam int CTRL_IE_BIT = 1;
    localparam int CTRL_HR_BIT = 0;
    localparam int ADDR_CTRL   = 0;
    localparam int ADDR_GSTAT  = 1;
    localparam int ADDR_PORT0  = 2;
endpackage

// File: rtl/irqagg_port.sv
module irqagg_port #(
    parameter int               REG_W   = 32,
    parameter logic [REG_W-1:0] EN_MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [REG_W-1:0] evt_set,
    input  logic             stat_w1c,
    input  logic             en_wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] stat,
    output logic [REG_W-1:0] en,
    output logic             hit
);
    logic [REG_W-1:0] clr_bits;

    assign clr_bits = stat_w1c ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat <= '0;
            en   <= '0;
        end else if (clr) begin
            stat <= '0;
            en   <= '0;
        end else begin
            stat <= (stat & ~clr_bits) | evt_set;
            if (en_wr) en <= wdata & EN_MASK;
        end
    end

    assign hit = |(stat & en);
endmodule

// File: rtl/irqagg_sig.sv
module irqagg_sig
    import irqagg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic eval,
    input  logic pending,
    input  logic msi_en,
    output logic msi_pulse,
    output logic irq_line
);
    line_state_e state_q, state_d;
    logic        pulse_q, pulse_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LINE_IDLE;
            pulse_q <= 1'b0;
        end else begin
            state_q <= state_d;
            pulse_q <= pulse_d;
        end
    end

    always_comb begin
        state_d = state_q;
        pulse_d = 1'b0;
        if (eval) begin
            pulse_d = pending && msi_en;
            unique case (state_q)
                LINE_IDLE: if (pending && !msi_en) state_d = LINE_HELD;
                LINE_HELD: if (!pending)           state_d = LINE_IDLE;
                default:   state_d = LINE_IDLE;
            endcase
        end
        if (clr) begin
            state_d = LINE_IDLE;
            pulse_d = 1'b0;
        end
    end

    assign msi_pulse = pulse_q;
    assign irq_line  = (state_q == LINE_HELD);
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
    import irqagg_pkg::*;
#(
    parameter int               NPORTS  = 4,
    parameter int               REG_W   = 32,
    parameter logic [REG_W-1:0] EN_MASK = 32'hFDC0_00FF,
    localparam int              NREGS   = ADDR_PORT0 + 2 * NPORTS,
    localparam int              ADDR_W  = $clog2(NREGS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         msi_en,
    input  logic [NPORTS-1:0][REG_W-1:0] evt_set,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [REG_W-1:0]             wr_data,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [REG_W-1:0]             rd_data,
    output logic                         msi_pulse,
    output logic                         irq_line
);
    logic                         ctrl_ie;
    logic                         eval_q;
    logic [NPORTS-1:0]            gstat;
    logic [NPORTS-1:0]            hits;
    logic [NPORTS-1:0][REG_W-1:0] stat_all;
    logic [NPORTS-1:0][REG_W-1:0] en_all;
    logic                         ctrl_wr, hba_rst, gstat_wr, valid_wr, pending;
    logic [NPORTS-1:0]            gstat_clr;

    assign ctrl_wr   = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
    assign hba_rst   = ctrl_wr && wr_data[CTRL_HR_BIT];
    assign gstat_wr  = wr_en && (wr_addr == ADDR_W'(ADDR_GSTAT));
    assign valid_wr  = wr_en && (32'(wr_addr) < NREGS);
    assign gstat_clr = gstat_wr ? wr_data[NPORTS-1:0] : '0;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        irqagg_port #(.REG_W(REG_W), .EN_MASK(EN_MASK)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (hba_rst),
            .evt_set  (evt_set[p]),
            .stat_w1c (wr_en && (wr_addr == ADDR_W'(ADDR_PORT0 + 2 * p))),
            .en_wr    (wr_en && (wr_addr == ADDR_W'(ADDR_PORT0 + 2 * p + 1))),
            .wdata    (wr_data),
            .stat     (stat_all[p]),
            .en       (en_all[p]),
            .hit      (hits[p])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_ie <= 1'b0;
            eval_q  <= 1'b0;
            gstat   <= '0;
        end else if (hba_rst) begin
            ctrl_ie <= 1'b0;
            eval_q  <= 1'b0;
            gstat   <= '0;
        end else begin
            if (ctrl_wr) ctrl_ie <= wr_data[CTRL_IE_BIT];
            eval_q <= valid_wr || (|evt_set);
            gstat  <= (gstat & ~gstat_clr) | (eval_q ? hits : '0);
        end
    end

    assign pending = ctrl_ie && ((gstat | hits) != '0);

    irqagg_sig u_sig (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (hba_rst),
        .eval      (eval_q),
        .pending   (pending),
        .msi_en    (msi_en),
        .msi_pulse (msi_pulse),
        .irq_line  (irq_line)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(ADDR_CTRL)) begin
            rd_data[CTRL_AE_BIT] = 1'b1;
            rd_data[CTRL_IE_BIT] = ctrl_ie;
        end else if (rd_addr == ADDR_W'(ADDR_GSTAT)) begin
            rd_data[NPORTS-1:0] = gstat;
        end
        for (int p = 0; p < NPORTS; p++) begin
            if (rd_addr == ADDR_W'(ADDR_PORT0 + 2 * p))     rd_data = stat_all[p];
            if (rd_addr == ADDR_W'(ADDR_PORT0 + 2 * p + 1)) rd_data = en_all[p];
        end
    end
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
    parameter int               NPORTS  = 4,
    parameter int               REG_W   = 32,
    parameter logic [REG_W-1:0] EN_MASK = 32'hFDC0_00FF,
    parameter int               ADDR_W  = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         wr_en,
    input logic [ADDR_W-1:0]            wr_addr,
    input logic [REG_W-1:0]             wr_data,
    input logic                         msi_en,
    input logic                         msi_pulse,
    input logic                         irq_line,
    input logic                         ie,
    input logic                         eval_q,
    input logic [NPORTS-1:0][REG_W-1:0] en_all
);
    logic ctrl_w, hr_w;
    assign ctrl_w = wr_en && (wr_addr == '0);
    assign hr_w   = ctrl_w && wr_data[0];

    assert_pulse_on_eval_R6: assert property (@(posedge clk) disable iff (!rst_n)
        msi_pulse |-> ($past(eval_q) && $past(msi_en) && $past(ie)));

    assert_line_rise_legacy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_line) |-> ($past(eval_q) && !$past(msi_en) && $past(ie)));

    assert_line_moves_on_eval_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(irq_line) |-> ($past(eval_q) || $past(hr_w)));

    assert_hba_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hr_w |=> (!irq_line && !ie && !msi_pulse));

    assert_ie_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_w && !wr_data[0]) |=> (ie == $past(wr_data[1])));

    for (genvar p = 0; p < NPORTS; p++) begin : g_mask
        assert_en_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (en_all[p] & ~EN_MASK) == '0);
    end
endmodule

bind irqagg_top irqagg_chk #(
    .NPORTS (NPORTS),
    .REG_W  (REG_W),
    .EN_MASK(EN_MASK),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .msi_en    (msi_en),
    .msi_pulse (msi_pulse),
    .irq_line  (irq_line),
    .ie        (ctrl_ie),
    .eval_q    (eval_q),
    .en_all    (en_all)
);

// File: tb/sim_irqagg_top.sv
`timescale 1ns/1ps
module sim_irqagg_top;
    localparam int NPORTS = 4;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 4;
    localparam int K_REG = 0, K_PULSE = 1, K_LINE = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic msi_en = 1'b0;
    logic [NPORTS-1:0][REG_W-1:0] evt_set = '0;
    logic wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [REG_W-1:0] wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [REG_W-1:0] rd_data;
    logic msi_pulse, irq_line;

    always #2.5 clk = ~clk;

    irqagg_top #(.NPORTS(NPORTS), .REG_W(REG_W)) u0 (
        .clk(clk), .rst_n(rst_n), .msi_en(msi_en), .evt_set(evt_set),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .msi_pulse(msi_pulse), .irq_line(irq_line)
    );

    typedef struct {
        int          kind;
        int          addr;
        logic [31:0] exp;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;

    task automatic expect_item(input int kind, input int addr, input logic [31:0] exp, input string tag);
        exp_t e;
        e.kind = kind; e.addr = addr; e.exp = exp; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: pops expectations and compares them with the outputs
    initial begin
        forever begin
            @(negedge clk);
            #0.2;
            while (exp_q.size() > 0) begin
                exp_t e;
                logic [31:0] act;
                e = exp_q.pop_front();
                if (e.kind == K_REG) begin
                    rd_addr = ADDR_W'(e.addr);
                    #0.1;
                    act = rd_data;
                end else if (e.kind == K_PULSE) begin
                    act = {31'b0, msi_pulse};
                end else begin
                    act = {31'b0, irq_line};
                end
                n_cmp++;
                if (act !== e.exp) begin
                    n_bad++;
                    $display("FAIL %s kind=%0d addr=%0d actual=%h expected=%h", e.tag, e.kind, e.addr, act, e.exp);
                end
            end
        end
    end

    task automatic wr_drive(input int a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic op_write(input int a, input logic [31:0] d);
        wr_drive(a, d);
        @(negedge clk);
    endtask

    task automatic op_event(input int p, input logic [31:0] bits);
        evt_set[p] = bits;
        @(negedge clk);
        evt_set = '0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        expect_item(K_REG, 0, 32'h8000_0000, "R1 ctrl");
        expect_item(K_REG, 1, 32'h0, "R1 gstat");
        expect_item(K_REG, 2, 32'h0, "R1 port0 status");
        expect_item(K_REG, 9, 32'h0, "R1 port3 enable");
        expect_item(K_LINE, 0, 32'h0, "R1 line");
        expect_item(K_PULSE, 0, 32'h0, "R1 pulse");

        // R3 enable masking
        op_write(3, 32'hFFFF_FFFF);
        expect_item(K_REG, 3, 32'hFDC0_00FF, "R3 port0 enable mask");

        // R2/R4/R5 event with interrupts disabled
        op_event(0, 32'h1);
        expect_item(K_REG, 2, 32'h1, "R2 port0 status set");
        expect_item(K_REG, 1, 32'h1, "R4 gstat bit0");
        expect_item(K_LINE, 0, 32'h0, "R5 line low with IE=0");

        // R10/R9/R7 enable interrupts in legacy mode
        wr_drive(0, 32'h0000_00F2);
        expect_item(K_LINE, 0, 32'h0, "R9 line not yet up one edge after write");
        @(negedge clk);
        expect_item(K_REG, 0, 32'h8000_0002, "R10 ctrl IE set, other bits ignored");
        expect_item(K_LINE, 0, 32'h1, "R7 line raised");
        expect_item(K_PULSE, 0, 32'h0, "R7 no pulse in legacy mode");

        // R2/R4/R7 clear port status, gstat sticky keeps line
        op_write(2, 32'h1);
        expect_item(K_REG, 2, 32'h0, "R2 port0 status cleared");
        expect_item(K_REG, 1, 32'h1, "R4 gstat sticky");
        expect_item(K_LINE, 0, 32'h1, "R7 line held");

        // R4/R7 clear gstat releases line
        op_write(1, 32'h1);
        expect_item(K_REG, 1, 32'h0, "R4 gstat cleared");
        expect_item(K_LINE, 0, 32'h0, "R7 line released");

        // R6 message mode
        msi_en = 1'b1;
        op_write(5, 32'h8);
        expect_item(K_REG, 5, 32'h8, "R3 port1 enable");
        expect_item(K_PULSE, 0, 32'h0, "R6 no pulse when idle");
        op_event(1, 32'h8);
        expect_item(K_PULSE, 0, 32'h1, "R6 pulse on pending eval");
        expect_item(K_LINE, 0, 32'h0, "R6 line stays low");
        expect_item(K_REG, 1, 32'h2, "R4 gstat bit1");
        @(negedge clk);
        expect_item(K_PULSE, 0, 32'h0, "R6 pulse lasts one cycle");
        op_write(5, 32'h8);
        expect_item(K_PULSE, 0, 32'h1, "R6 pulse on each eval");
        op_write(4, 32'h8);
        expect_item(K_PULSE, 0, 32'h1, "R6 pulse from sticky gstat");
        op_write(1, 32'h2);
        expect_item(K_PULSE, 0, 32'h0, "R6 no pulse once cleared");
        expect_item(K_REG, 1, 32'h0, "R4 gstat cleared again");

        // R2 same-cycle set and clear
        evt_set[2] = 32'h10;
        wr_drive(6, 32'h10);
        evt_set = '0;
        @(negedge clk);
        expect_item(K_REG, 6, 32'h10, "R2 set wins over clear");
        expect_item(K_REG, 1, 32'h0, "R4 no gstat without enable");
        expect_item(K_PULSE, 0, 32'h0, "R4 no pulse without enable");

        // R3 masked cause
        op_write(9, 32'h0200_0000);
        expect_item(K_REG, 9, 32'h0, "R3 masked enable bit dropped");
        op_event(3, 32'h0200_0000);
        expect_item(K_REG, 8, 32'h0200_0000, "R2 port3 status");
        expect_item(K_REG, 1, 32'h0, "R3 masked cause not in gstat");
        expect_item(K_PULSE, 0, 32'h0, "R3 masked cause no pulse");

        // R5 IE gating in legacy mode
        msi_en = 1'b0;
        op_write(7, 32'h10);
        expect_item(K_REG, 1, 32'h4, "R4 gstat bit2");
        expect_item(K_LINE, 0, 32'h1, "R7 line raised port2");
        op_write(0, 32'h0);
        expect_item(K_REG, 0, 32'h8000_0000, "R10 IE cleared");
        expect_item(K_LINE, 0, 32'h0, "R5 line released by IE=0");
        op_write(0, 32'h2);
        expect_item(K_LINE, 0, 32'h1, "R5 line back with IE=1");

        // R8 adapter reset
        wr_drive(0, 32'h1);
        expect_item(K_LINE, 0, 32'h0, "R8 line low at reset edge");
        @(negedge clk);
        expect_item(K_REG, 0, 32'h8000_0000, "R8 ctrl after reset");
        expect_item(K_REG, 1, 32'h0, "R8 gstat after reset");
        expect_item(K_REG, 3, 32'h0, "R8 enable after reset");
        expect_item(K_REG, 6, 32'h0, "R8 status after reset");
        expect_item(K_LINE, 0, 32'h0, "R8 line stays low");

        repeat (3) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule